// File: doc/BRIEF.md
# Four-Accumulator Multiply-Accumulate Unit with Sticky Overflow

This block is a multiply-accumulate datapath with four accumulators. Each operation takes two 16-bit operands, a 2-bit accumulator index and an add/subtract select. It forms the product and adds it to, or subtracts it from, the chosen accumulator. Each accumulator holds 48 bits: a 32-bit word plus 16 extension bits of headroom. The accumulator is written on the next clock edge.

A status word controls the arithmetic and reports the outcome. Four control bits select saturating or wrapping overflow, unsigned or signed operands, fractional or integer format, and rounding or truncation of fractional products. Condition flags give the sign, zero and overflow state of the last result, and a 32-bit-word overflow indication. Each accumulator has its own sticky overflow flag. The general overflow flag is taken from the sticky flag of the accumulator that was just written. Software can write the low byte of the status word, load any accumulator directly and read any accumulator through a combinational read port.

Top module: `qmac_quad`

## Requirements
- R1: After reset the status word reads 0x0000_0000 and every accumulator reads zero.
- R2: A valid operation writes acc[dst] +/- (a*b) on the next edge and leaves the other accumulators unchanged. With status bit 6 clear, operands and accumulator are two's-complement signed.
- R3: With status bit 6 set, both operands are zero-extended and the accumulator is treated as an unsigned 48-bit value.
- R4: With status bit 5 set (fractional), the product is doubled and its low 16 bits are cleared (truncation, status bit 4 clear).
- R5: With bit 5 and bit 4 both set, 0x8000 is added to the doubled product before its low 16 bits are cleared. In integer mode bit 4 has no effect.
- R6: A final product outside the 32-bit range of the selected signedness sets the sticky flag of the destination accumulator. The sticky flag of accumulator k is status bit 8+k.
- R7: A sum outside the 48-bit range of the selected signedness sets that sticky flag. With status bit 7 set, the result is clamped to the nearest 48-bit limit (signed 0x7FFF_FFFF_FFFF / 0x8000_0000_0000, unsigned all ones / zero). With bit 7 clear, the low 48 bits are kept.
- R8: After an operation, status bit 3 (N) equals bit 47 of the written result and status bit 2 (Z) is set exactly when the result is zero.
- R9: After an operation, status bit 1 (V) equals the destination's sticky flag. Status bit 0 (EV) is set when the sum fits 48 bits but not 32 bits of the selected signedness.
- R10: A sticky flag stays set through later operations. A status write with data bit 1 clear clears all four sticky flags, and one with bit 1 set keeps them. A status write sets bits 7:0 to the data and cannot set a sticky flag. Bits 31:12 read zero.
- R11: A direct load writes the 48-bit value into the indexed accumulator and clears that accumulator's sticky flag.
- R12: If a load and an operation hit the same accumulator in one cycle, the load wins and the operation is dropped with no flag change. If they hit different accumulators, both take effect.
- R13: If a status write and an operation share a cycle, the operation uses the old control bits. Bits 7:0 take the written data, the sticky clear applies first, and the operation's overflow is then recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_sub | input | 1 | 1 subtracts the product, 0 adds it |
| op_dst | input | 2 | Destination accumulator index |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| acc_we | input | 1 | Direct accumulator load |
| acc_widx | input | 2 | Index of the accumulator to load |
| acc_wdata | input | 48 | Value to load |
| sr_we | input | 1 | Status write strobe |
| sr_wdata | input | 8 | New control and condition bits |
| rd_idx | input | 2 | Accumulator read select |
| rd_acc | output | 48 | Selected accumulator value |
| sr_rd | output | 32 | Status word |

## Verification
Two collisions matter most. An operation can share a cycle with a status write, and it can share a cycle with a direct load. For the first, the bench changes the control bits and clears the sticky flags in the same cycle as a fractional operation that overflows. It then judges whether the old mode was used and whether the new overflow survives the clear. For the second, it loads the operation's own accumulator and then a different one, and expects the load alone in the first case and both effects in the second.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
  parameter int OPW  = 16;
  parameter int PW   = 2 * OPW;
  parameter int ACCW = 48;
  parameter int LOW  = 32;
  parameter int WW   = ACCW + 2;
  parameter int NACC = 4;
  parameter int IDXW = $clog2(NACC);
  parameter int CTLW = 8;
  parameter int SRW  = 32;

  typedef struct packed {
    logic sat;
    logic uns;
    logic frac;
    logic rnd;
  } mode_t;

  typedef logic signed [WW-1:0] wide_t;

  function automatic wide_t widen_op(input logic [OPW-1:0] v, input logic uns);
    return uns ? wide_t'({{(WW-OPW){1'b0}}, v}) : wide_t'({{(WW-OPW){v[OPW-1]}}, v});
  endfunction

  function automatic wide_t widen_acc(input logic [ACCW-1:0] v, input logic uns);
    return uns ? wide_t'({{(WW-ACCW){1'b0}}, v}) : wide_t'({{(WW-ACCW){v[ACCW-1]}}, v});
  endfunction

  // value fits in 'bits' bits of the chosen signedness
  function automatic logic fits(input wide_t v, input int bits, input logic uns);
    wide_t hi;
    if (uns) begin
      hi = v >>> bits;
      return !v[WW-1] && (hi == '0);
    end
    hi = v >>> (bits - 1);
    return (hi == '0) || (hi == '1);
  endfunction

  function automatic wide_t form_product(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                                         input mode_t m);
    wide_t p;
    p = widen_op(a, m.uns) * widen_op(b, m.uns);
    if (m.frac) begin
      p = p <<< 1;
      if (m.rnd) p = p + (wide_t'(1) <<< (OPW - 1));
      p[OPW-1:0] = '0;
    end
    return p;
  endfunction

  function automatic logic [ACCW-1:0] clamp(input logic neg, input logic uns);
    if (uns) return neg ? '0 : '1;
    return neg ? {1'b1, {(ACCW-1){1'b0}}} : {1'b0, {(ACCW-1){1'b1}}};
  endfunction
endpackage

// File: rtl/qmac_product.sv
module qmac_product
  import qmac_pkg::*;
(
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  mode_t          mode_i,
  output wide_t          prod_o,
  output logic           pov_o
);
  assign prod_o = form_product(a_i, b_i, mode_i);
  assign pov_o  = !fits(prod_o, PW, mode_i.uns);
endmodule

// File: rtl/qmac_accum.sv
module qmac_accum
  import qmac_pkg::*;
(
  input  logic [ACCW-1:0] acc_i,
  input  wide_t           prod_i,
  input  logic            sub_i,
  input  mode_t           mode_i,
  output logic [ACCW-1:0] res_o,
  output logic            aov_o,
  output logic            ev_o
);
  wide_t acc_w, sum;

  assign acc_w = widen_acc(acc_i, mode_i.uns);
  assign sum   = sub_i ? (acc_w - prod_i) : (acc_w + prod_i);
  assign aov_o = !fits(sum, ACCW, mode_i.uns);
  assign ev_o  = !aov_o && !fits(sum, LOW, mode_i.uns);
  assign res_o = (aov_o && mode_i.sat) ? clamp(sum[WW-1], mode_i.uns) : sum[ACCW-1:0];
endmodule

// File: rtl/qmac_flags.sv
module qmac_flags
  import qmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_fire_i,
  input  logic [IDXW-1:0] dst_i,
  input  logic            ovf_i,
  input  logic            res_n_i,
  input  logic            res_z_i,
  input  logic            ev_i,
  input  logic            sr_we_i,
  input  logic [CTLW-1:0] sr_wd_i,
  input  logic            ld_we_i,
  input  logic [IDXW-1:0] ld_idx_i,
  output logic [NACC-1:0] pav_o,
  output logic [CTLW-1:0] ctl_o
);
  logic [NACC-1:0] pav_q, pav_n;
  logic [CTLW-1:0] ctl_q, ctl_n;
  logic            sticky_clr;

  assign sticky_clr = sr_we_i && !sr_wd_i[1];

  always_comb begin
    pav_n = pav_q;
    if (sticky_clr) pav_n = '0;
    if (ld_we_i) pav_n[ld_idx_i] = 1'b0;
    if (op_fire_i && ovf_i) pav_n[dst_i] = 1'b1;
    ctl_n = ctl_q;
    if (op_fire_i) ctl_n[3:0] = {res_n_i, res_z_i, pav_n[dst_i], ev_i};
    if (sr_we_i) ctl_n = sr_wd_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pav_q <= '0;
      ctl_q <= '0;
    end else begin
      pav_q <= pav_n;
      ctl_q <= ctl_n;
    end
  end

  assign pav_o = pav_q;
  assign ctl_o = ctl_q;

  // R9
  v_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire_i && !sr_we_i |=> ctl_q[1] == pav_q[$past(dst_i)]);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire_i && ovf_i |=> pav_q[$past(dst_i)]);

  for (genvar g = 0; g < NACC; g++) begin : g_sticky
    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pav_q[g]) |-> $past(sticky_clr) || $past(ld_we_i && ld_idx_i == IDXW'(g)));
  end
endmodule

// File: rtl/qmac_quad.sv
module qmac_quad
  import qmac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_sub,
  input  logic [IDXW-1:0] op_dst,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic            acc_we,
  input  logic [IDXW-1:0] acc_widx,
  input  logic [ACCW-1:0] acc_wdata,
  input  logic            sr_we,
  input  logic [CTLW-1:0] sr_wdata,
  input  logic [IDXW-1:0] rd_idx,
  output logic [ACCW-1:0] rd_acc,
  output logic [SRW-1:0]  sr_rd
);
  localparam int PADW = SRW - NACC - CTLW;

  logic [ACCW-1:0] bank_q [NACC];
  logic [NACC-1:0] pav;
  logic [CTLW-1:0] ctl;
  mode_t           mode;
  wide_t           prod;
  logic            pov, aov, ev, op_fire, ovf;
  logic [ACCW-1:0] res;

  assign mode    = mode_t'(ctl[7:4]);
  assign op_fire = op_valid && !(acc_we && acc_widx == op_dst);
  assign ovf     = pov || aov;

  qmac_product u_prod (
    .a_i(op_a), .b_i(op_b), .mode_i(mode), .prod_o(prod), .pov_o(pov)
  );

  qmac_accum u_acc (
    .acc_i(bank_q[op_dst]), .prod_i(prod), .sub_i(op_sub), .mode_i(mode),
    .res_o(res), .aov_o(aov), .ev_o(ev)
  );

  qmac_flags u_flags (
    .clk(clk), .rst_n(rst_n), .op_fire_i(op_fire), .dst_i(op_dst), .ovf_i(ovf),
    .res_n_i(res[ACCW-1]), .res_z_i(res == '0), .ev_i(ev),
    .sr_we_i(sr_we), .sr_wd_i(sr_wdata), .ld_we_i(acc_we), .ld_idx_i(acc_widx),
    .pav_o(pav), .ctl_o(ctl)
  );

  for (genvar g = 0; g < NACC; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                                bank_q[g] <= '0;
      else if (acc_we && acc_widx == IDXW'(g))   bank_q[g] <= acc_wdata;
      else if (op_fire && op_dst == IDXW'(g))    bank_q[g] <= res;
    end
  end

  assign rd_acc = bank_q[rd_idx];
  assign sr_rd  = {{PADW{1'b0}}, pav, ctl};

  // R8
  nz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && !sr_we |=> !(sr_rd[3] && sr_rd[2]));

  // R11
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> bank_q[$past(acc_widx)] == $past(acc_wdata));

  // R11
  load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we && !(op_fire && pov) |=> !pav[$past(acc_widx)]);
endmodule

// File: tb/qmac_quad_tb.sv
module qmac_quad_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_sub = 1'b0;
  logic [1:0]  op_dst = '0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        acc_we = 1'b0;
  logic [1:0]  acc_widx = '0;
  logic [47:0] acc_wdata = '0;
  logic        sr_we = 1'b0;
  logic [7:0]  sr_wdata = '0;
  logic [1:0]  rd_idx = '0;
  logic [47:0] rd_acc;
  logic [31:0] sr_rd;

  always #5 clk = ~clk;

  qmac_quad dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub), .op_dst(op_dst),
    .op_a(op_a), .op_b(op_b), .acc_we(acc_we), .acc_widx(acc_widx), .acc_wdata(acc_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .rd_idx(rd_idx), .rd_acc(rd_acc), .sr_rd(sr_rd)
  );

  typedef struct {
    string       tag;
    logic [1:0]  obs;
    logic [47:0] acc;
    logic [31:0] sr;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  localparam longint P31 = 64'sd2147483648;
  localparam longint P32 = 64'sd4294967296;
  localparam longint P47 = 64'sd140737488355328;
  localparam longint P48 = 64'sd281474976710656;

  logic [47:0] m_acc [4];
  logic [3:0]  m_pav = '0;
  logic [7:0]  m_ctl = '0;

  task automatic step(input string tag, input bit opv, input bit sub, input bit [1:0] dst,
                      input bit [15:0] a, input bit [15:0] b, input bit lw, input bit [1:0] li,
                      input bit [47:0] ld, input bit sw, input bit [7:0] sd, input bit [1:0] obs);
    bit sat, uns, frc, rnd, fire, pov, aov, ev;
    longint pa, pb, p, av, s;
    logic [47:0] res;
    logic [3:0]  pav_n;
    exp_t it;
    sat = m_ctl[7]; uns = m_ctl[6]; frc = m_ctl[5]; rnd = m_ctl[4];
    fire = opv && !(lw && li == dst);
    pav_n = m_pav;
    if (sw && !sd[1]) pav_n = '0;
    if (lw) pav_n[li] = 1'b0;
    if (fire) begin
      pa = uns ? longint'(a) : longint'($signed(a));
      pb = uns ? longint'(b) : longint'($signed(b));
      p = pa * pb;
      if (frc) begin
        p = p * 2;
        if (rnd) p = p + 32768;
        p = p - (p & 64'sd65535);
      end
      pov = uns ? (p >= P32) : (p < -P31 || p >= P31);
      av = uns ? longint'(m_acc[dst]) : longint'($signed(m_acc[dst]));
      s = sub ? av - p : av + p;
      aov = uns ? (s < 0 || s >= P48) : (s < -P47 || s >= P47);
      ev = !aov && (uns ? (s >= P32) : (s < -P31 || s >= P31));
      if (aov && sat)
        res = uns ? (s < 0 ? 48'h0 : 48'hFFFF_FFFF_FFFF)
                  : (s < 0 ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF);
      else
        res = s[47:0];
      m_acc[dst] = res;
      if (pov || aov) pav_n[dst] = 1'b1;
      m_ctl[3:0] = {res[47], res == 48'h0, pav_n[dst], ev};
    end
    if (sw) m_ctl = sd;
    if (lw) m_acc[li] = ld;
    m_pav = pav_n;
    @(negedge clk);
    op_valid = opv; op_sub = sub; op_dst = dst; op_a = a; op_b = b;
    acc_we = lw; acc_widx = li; acc_wdata = ld; sr_we = sw; sr_wdata = sd;
    @(posedge clk);
    it.tag = tag; it.obs = obs; it.acc = m_acc[obs]; it.sr = {20'h0, m_pav, m_ctl};
    q.push_back(it);
  endtask

  task automatic op(input string tag, input bit sub, input bit [1:0] dst,
                    input bit [15:0] a, input bit [15:0] b);
    step(tag, 1'b1, sub, dst, a, b, 1'b0, 2'd0, 48'h0, 1'b0, 8'h0, dst);
  endtask

  task automatic load(input string tag, input bit [1:0] idx, input bit [47:0] v);
    step(tag, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 1'b1, idx, v, 1'b0, 8'h0, idx);
  endtask

  task automatic wsr(input string tag, input bit [7:0] v);
    step(tag, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 1'b0, 2'd0, 48'h0, 1'b1, v, 2'd0);
  endtask

  task automatic peek(input string tag, input bit [1:0] idx);
    step(tag, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 1'b0, 2'd0, 48'h0, 1'b0, 8'h0, idx);
  endtask

  // monitor: pops one expected item per cycle and compares at the ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      rd_idx = it.obs;
      #1;
      checks++;
      if (rd_acc !== it.acc) begin
        errors++;
        $display("FAIL %s acc%0d actual %h expected %h", it.tag, it.obs, rd_acc, it.acc);
      end
      checks++;
      if (sr_rd !== it.sr) begin
        errors++;
        $display("FAIL %s status actual %h expected %h", it.tag, sr_rd, it.sr);
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    peek("R1", 2'd0);
    peek("R1", 2'd3);
    op("R2", 1'b0, 2'd0, 16'd3, 16'd4);
    op("R2", 1'b1, 2'd1, 16'hFFFB, 16'd7);
    op("R2", 1'b0, 2'd0, 16'hFFFE, 16'd9);
    peek("R2", 2'd1);
    wsr("R10", 8'h40);
    op("R3", 1'b0, 2'd2, 16'hFFFF, 16'd2);
    wsr("R10", 8'h20);
    op("R4", 1'b0, 2'd3, 16'h1234, 16'h5678);
    op("R4", 1'b1, 2'd3, 16'h1234, 16'h5678);
    wsr("R10", 8'h30);
    op("R5", 1'b0, 2'd2, 16'h1234, 16'h5678);
    op("R5", 1'b0, 2'd2, 16'hEDCC, 16'h5678);
    op("R6", 1'b0, 2'd3, 16'h8000, 16'h8000);
    op("R10", 1'b0, 2'd3, 16'd1, 16'h0);
    op("R9", 1'b0, 2'd0, 16'd1, 16'h0);
    wsr("R5", 8'h10);
    op("R5", 1'b0, 2'd0, 16'd5, 16'd5);
    wsr("R10", 8'h62);
    op("R6", 1'b0, 2'd1, 16'hFFFF, 16'hFFFF);
    wsr("R10", 8'h82);
    load("R11", 2'd1, 48'h7FFF_FFFF_FFFF);
    op("R7", 1'b0, 2'd1, 16'd1, 16'd1);
    wsr("R10", 8'h00);
    load("R11", 2'd2, 48'h7FFF_FFFF_FFFF);
    op("R7", 1'b0, 2'd2, 16'd1, 16'd1);
    load("R11", 2'd0, 48'h0000_7FFF_FFFF);
    op("R9", 1'b0, 2'd0, 16'd1, 16'd1);
    load("R11", 2'd0, 48'h5);
    op("R8", 1'b1, 2'd0, 16'd5, 16'd1);
    wsr("R10", 8'hC0);
    load("R11", 2'd0, 48'h0);
    op("R7", 1'b1, 2'd0, 16'd1, 16'd1);
    wsr("R10", 8'h00);
    step("R12", 1'b1, 1'b0, 2'd1, 16'd9, 16'd9, 1'b1, 2'd1, 48'h1234_5678_9ABC,
         1'b0, 8'h0, 2'd1);
    step("R12", 1'b1, 1'b0, 2'd1, 16'd9, 16'd9, 1'b1, 2'd2, 48'hABC, 1'b0, 8'h0, 2'd1);
    peek("R12", 2'd2);
    wsr("R10", 8'h20);
    step("R13", 1'b1, 1'b0, 2'd0, 16'h8000, 16'h8000, 1'b0, 2'd0, 48'h0,
         1'b1, 8'h00, 2'd0);
    op("R13", 1'b0, 2'd0, 16'd2, 16'd3);
    @(negedge clk);
    op_valid = 1'b0; acc_we = 1'b0; sr_we = 1'b0;
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule